// File: doc/BRIEF.md
# Relay Leg and Early-Stop Controller

This block sequences the iteration loop of an iterative belief-propagation decoder that runs each decode as a series of relay legs. The node datapaths live outside the block. After each decoder iteration they present the syndrome mismatch vector and the current hard-decision vector, together with a one-cycle valid strobe. One iteration takes two clock cycles, so in normal use the strobe arrives every other cycle. The block counts the unsatisfied checks and tracks the lowest count reached in the current leg. A leg ends when that count has not improved for a set number of iterations, or when the leg reaches its iteration cap. At each leg boundary the block tells the datapath to keep its beliefs and to load the next memory-bias strength. The strengths come from a table that the parameters compute and that the leg number indexes.

A syndrome with no failing checks is a valid solution, and its weight is the popcount of its hard-decision vector. In single-shot mode the first valid solution ends the decode at once. In ensemble mode a valid solution only closes the current leg. The block keeps the lightest valid solution it has seen and reports it once the final leg ends. When the decode finishes, the block raises a done pulse and presents the best solution. A fail flag is raised if no iteration produced a valid solution.

Top module: `relay_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, carry_o and load_str_o are 0, leg_o is 0 and best_o is all zeros.
- R2: A start_i seen while idle makes the next cycle show busy_o=1, leg_o=0, load_str_o=1, fail_o=0 and best_o=0, and it samples ensemble_i as the mode for the decode. A start_i seen while busy has no effect.
- R3: strength_o equals the signed value STR_BASE + leg_o*STR_STEP, truncated to STR_W bits. With the defaults the legs 0..3 give -24, -8, 8 and 24.
- R4: iter_valid_i while idle changes no output.
- R5: A leg ends on the iteration that makes STALL_LIM consecutive iterations in which the failing-check count (the popcount of syndrome_i) is not strictly below the minimum so far in that leg. The minimum restarts with each leg.
- R6: A leg also ends on its LEG_ITERS-th iteration.
- R7: When a leg that is not the last one ends without finishing the decode, leg_o increments and carry_o and load_str_o pulse in the cycle after the iteration.
- R8: In single-shot mode (ensemble_i=0 at start), an iteration whose syndrome is zero ends the decode. In the next cycle done_o=1, busy_o=0 and best_o holds that hard-decision vector.
- R9: In ensemble mode (ensemble_i=1 at start), a zero syndrome ends the current leg. best_o takes that hard-decision vector only if no valid solution is held yet, or if its popcount is strictly lower than the held one. A tie keeps the earlier vector.
- R10: When the last leg ends, done_o pulses, busy_o drops and fail_o is 1 exactly when no valid solution was seen. fail_o and best_o hold until the next accepted start.
- R11: done_o, carry_o and load_str_o are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a decode (accepted only when idle) |
| ensemble_i | input | 1 | Mode sampled at start: 1 = ensemble, 0 = single-shot |
| iter_valid_i | input | 1 | One iteration's result is on syndrome_i and hard_i |
| syndrome_i | input | N_CHK | Syndrome mismatch vector, 1 = failing check |
| hard_i | input | N_BIT | Hard-decision vector of the iteration |
| busy_o | output | 1 | Decode in progress |
| leg_o | output | LW | Current leg number |
| strength_o | output | STR_W | Signed memory-bias strength for the current leg |
| load_str_o | output | 1 | Datapath loads strength_o |
| carry_o | output | 1 | Datapath carries beliefs into the new leg |
| done_o | output | 1 | Decode finished |
| fail_o | output | 1 | Finished decode found no valid solution |
| best_o | output | N_BIT | Best valid hard-decision vector |

## Verification
The hardest state to reach from the ports is an ensemble decode that converges on several legs with different weights and with a tie, and whose last leg then ends on the iteration cap instead of on a stall. This is the only path where the keep-best rule, the tie rule and the final-leg exit interact. Directed sequences build it in steps: syndromes whose popcounts fall strictly each iteration keep the stall counter at zero, so the cap fires, and chosen hard vectors set the weights. A pseudo-random sweep in both modes then follows an arithmetic model of the leg, stall and best-keeping rules, iteration by iteration.

// File: rtl/relay_pkg.sv
package relay_pkg;
  function automatic int leg_strength(int base, int step, int leg);
    return base + leg * step;
  endfunction
endpackage

// File: rtl/relay_popcnt.sv
module relay_popcnt #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/relay_str_rom.sv
module relay_str_rom
  import relay_pkg::*;
#(
  parameter int N_LEGS   = 4,
  parameter int STR_W    = 8,
  parameter int STR_BASE = -24,
  parameter int STR_STEP = 16,
  parameter int LW       = $clog2(N_LEGS)
) (
  input  logic [LW-1:0]             leg_i,
  output logic signed [STR_W-1:0]   str_o
);
  logic signed [STR_W-1:0] tbl [N_LEGS];

  for (genvar l = 0; l < N_LEGS; l++) begin : g_leg
    assign tbl[l] = STR_W'(leg_strength(STR_BASE, STR_STEP, l));
  end

  assign str_o = tbl[leg_i];
endmodule

// File: rtl/relay_stall.sv
module relay_stall #(
  parameter int FW        = 4,
  parameter int STALL_LIM = 3,
  parameter int SW        = $clog2(STALL_LIM + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [FW-1:0] fails_i,
  output logic          hit_o
);
  // one spare bit so the reset minimum sits above any real count
  logic [FW:0]   min_q;
  logic [SW-1:0] cnt_q;
  logic          improve;

  assign improve = {1'b0, fails_i} < min_q;
  assign hit_o   = step_i && !improve && (cnt_q == SW'(STALL_LIM - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= '1;
      cnt_q <= '0;
    end else if (clr_i) begin
      min_q <= '1;
      cnt_q <= '0;
    end else if (step_i) begin
      if (improve) begin
        min_q <= {1'b0, fails_i};
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + SW'(1);
      end
    end
  end
endmodule

// File: rtl/relay_ctrl.sv
module relay_ctrl #(
  parameter int N_CHK     = 8,
  parameter int N_BIT     = 8,
  parameter int N_LEGS    = 4,
  parameter int LEG_ITERS = 6,
  parameter int STALL_LIM = 3,
  parameter int STR_W     = 8,
  parameter int STR_BASE  = -24,
  parameter int STR_STEP  = 16,
  localparam int LW = $clog2(N_LEGS),
  localparam int FW = $clog2(N_CHK + 1),
  localparam int WW = $clog2(N_BIT + 1),
  localparam int IW = $clog2(LEG_ITERS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    ensemble_i,
  input  logic                    iter_valid_i,
  input  logic [N_CHK-1:0]        syndrome_i,
  input  logic [N_BIT-1:0]        hard_i,
  output logic                    busy_o,
  output logic [LW-1:0]           leg_o,
  output logic signed [STR_W-1:0] strength_o,
  output logic                    load_str_o,
  output logic                    carry_o,
  output logic                    done_o,
  output logic                    fail_o,
  output logic [N_BIT-1:0]        best_o
);
  logic [FW-1:0] fails;
  logic [WW-1:0] wgt;
  logic [IW-1:0] iter_q;
  logic [WW-1:0] best_w_q;
  logic          best_valid_q, ens_q;
  logic          step, conv, stall_hit, leg_end, last_leg, finish, take;
  logic          start_go, leg_adv;

  relay_popcnt #(.W(N_CHK)) u_fail_cnt (.vec_i(syndrome_i), .cnt_o(fails));
  relay_popcnt #(.W(N_BIT)) u_wgt_cnt  (.vec_i(hard_i),     .cnt_o(wgt));

  relay_str_rom #(
    .N_LEGS(N_LEGS), .STR_W(STR_W), .STR_BASE(STR_BASE), .STR_STEP(STR_STEP)
  ) u_rom (.leg_i(leg_o), .str_o(strength_o));

  assign start_go = start_i && !busy_o;
  assign step     = iter_valid_i && busy_o;
  assign conv     = step && (fails == '0);
  assign leg_end  = step && (conv || stall_hit || iter_q == IW'(LEG_ITERS - 1));
  assign last_leg = leg_o == LW'(N_LEGS - 1);
  assign finish   = (conv && !ens_q) || (leg_end && last_leg);
  assign leg_adv  = leg_end && !finish;
  assign take     = conv && (!best_valid_q || wgt < best_w_q);

  relay_stall #(.FW(FW), .STALL_LIM(STALL_LIM)) u_stall (
    .clk_i, .rst_ni,
    .clr_i  (start_go || leg_adv),
    .step_i (step),
    .fails_i(fails),
    .hit_o  (stall_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o       <= 1'b0;
      leg_o        <= '0;
      iter_q       <= '0;
      ens_q        <= 1'b0;
      best_valid_q <= 1'b0;
      best_w_q     <= '0;
      best_o       <= '0;
      fail_o       <= 1'b0;
      load_str_o   <= 1'b0;
      carry_o      <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      load_str_o <= start_go || leg_adv;
      carry_o    <= leg_adv;
      done_o     <= finish;
      if (start_go) begin
        busy_o       <= 1'b1;
        leg_o        <= '0;
        iter_q       <= '0;
        ens_q        <= ensemble_i;
        best_valid_q <= 1'b0;
        best_w_q     <= '0;
        best_o       <= '0;
        fail_o       <= 1'b0;
      end else if (step) begin
        if (take) begin
          best_o       <= hard_i;
          best_w_q     <= wgt;
          best_valid_q <= 1'b1;
        end
        if (finish) begin
          busy_o <= 1'b0;
          fail_o <= !(best_valid_q || conv);
        end else if (leg_end) begin
          leg_o  <= leg_o + LW'(1);
          iter_q <= '0;
        end else begin
          iter_q <= iter_q + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/relay_ctrl_chk.sv
module relay_ctrl_chk #(
  parameter int N_LEGS = 4,
  parameter int LW     = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic [LW-1:0] leg_o,
  input logic          load_str_o,
  input logic          carry_o,
  input logic          done_o,
  input logic          fail_o
);
  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && load_str_o && leg_o == '0));

  assert_leg_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_o <= LW'(N_LEGS - 1));

  assert_leg_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (leg_o == $past(leg_o) + LW'(1)) && load_str_o);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_fail_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !fail_o);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_carry_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> !carry_o);
endmodule

bind relay_ctrl relay_ctrl_chk #(.N_LEGS(N_LEGS), .LW(LW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .leg_o(leg_o), .load_str_o(load_str_o), .carry_o(carry_o),
  .done_o(done_o), .fail_o(fail_o)
);

// File: tb/relay_ctrl_test.sv
module relay_ctrl_test;
  localparam int N_LEGS = 4, LEG_ITERS = 6, STALL_LIM = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, ensemble_i = 1'b0, iter_valid_i = 1'b0;
  logic [7:0] syndrome_i = '0, hard_i = '0;
  logic busy_o, load_str_o, carry_o, done_o, fail_o;
  logic [1:0] leg_o;
  logic signed [7:0] strength_o;
  logic [7:0] best_o;

  int tests = 0, fails = 0;

  // model state
  logic m_busy = 0, m_load = 0, m_carry = 0, m_done = 0, m_fail = 0;
  logic m_ens = 0, m_bv = 0, m_first = 1;
  int   m_leg = 0, m_it = 0, m_min = 0, m_stall = 0, m_bw = 0;
  logic [7:0] m_best = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  relay_ctrl uut (
    .clk_i(clk), .rst_ni, .start_i, .ensemble_i, .iter_valid_i,
    .syndrome_i, .hard_i, .busy_o, .leg_o, .strength_o, .load_str_o,
    .carry_o, .done_o, .fail_o, .best_o
  );

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string tag);
    logic [22:0] act, exp;
    logic signed [7:0] es;
    es  = 8'(-24 + m_leg * 16);   // R3 strength formula
    act = {busy_o, leg_o, load_str_o, carry_o, done_o, fail_o, best_o, strength_o};
    exp = {m_busy, 2'(m_leg), m_load, m_carry, m_done, m_fail, m_best, es};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cycle_chk(input string tag);
    @(negedge clk);
    m_load = 0; m_carry = 0; m_done = 0;
    chk(tag);
  endtask

  task automatic start(input logic ens, input string tag);
    @(negedge clk);
    start_i = 1; ensemble_i = ens;
    @(negedge clk);
    start_i = 0;
    m_load = 0; m_carry = 0; m_done = 0;
    if (!m_busy) begin
      m_busy = 1; m_leg = 0; m_it = 0; m_ens = ens; m_bv = 0; m_bw = 0;
      m_best = '0; m_fail = 0; m_first = 1; m_stall = 0; m_load = 1;
    end
    chk(tag);
  endtask

  task automatic iter(input logic [7:0] s, input logic [7:0] h, input string tag);
    int f, w;
    logic cv, hit, endl, fin;
    @(negedge clk);
    iter_valid_i = 1; syndrome_i = s; hard_i = h;
    @(negedge clk);
    iter_valid_i = 0;
    m_load = 0; m_carry = 0; m_done = 0;
    if (m_busy) begin
      f = $countones(s); w = $countones(h); cv = (f == 0);
      if (m_first || f < m_min) begin m_min = f; m_stall = 0; m_first = 0; end
      else m_stall++;
      hit  = (m_stall == STALL_LIM);
      endl = cv || hit || (m_it + 1 == LEG_ITERS);
      if (cv && (!m_bv || w < m_bw)) begin m_bv = 1; m_bw = w; m_best = h; end
      fin = (cv && !m_ens) || (endl && m_leg == N_LEGS - 1);
      if (fin) begin m_busy = 0; m_done = 1; m_fail = !m_bv; end
      else if (endl) begin
        m_leg++; m_it = 0; m_first = 1; m_stall = 0; m_load = 1; m_carry = 1;
      end else m_it++;
    end
    chk(tag);
    cycle_chk("R11 pulse low");
  endtask

  initial begin
    #9;
    @(negedge clk);
    chk("R1 reset");
    rst_ni = 1;
    cycle_chk("R1 after release");
    iter(8'h00, 8'hFF, "R4 idle iter");
    // single-shot: stall ends leg 0, then convergence ends decode
    start(0, "R2 start");
    iter(8'h07, 8'h01, "R5 first");
    iter(8'h0E, 8'h02, "R5 stall1");
    iter(8'h70, 8'h03, "R5 stall2");
    iter(8'h83, 8'h04, "R5 R7 stall limit leg end");
    start(1, "R2 start ignored while busy");
    iter(8'h01, 8'h05, "R3 leg1");
    iter(8'h00, 8'h0F, "R8 converge");
    cycle_chk("R10 held");
    // ensemble: tie keeps earlier, lighter replaces, last leg hits cap
    start(1, "R2 ensemble start");
    iter(8'h00, 8'h33, "R9 first valid");
    iter(8'h00, 8'h0F, "R9 tie keeps earlier");
    iter(8'h00, 8'h01, "R9 lighter wins");
    iter(8'h3F, 8'h00, "R6 f6");
    iter(8'h1F, 8'h00, "R6 f5");
    iter(8'h0F, 8'h00, "R6 f4");
    iter(8'h07, 8'h00, "R6 f3");
    iter(8'h03, 8'h00, "R6 f2");
    iter(8'h01, 8'h00, "R6 R10 cap on last leg");
    // no valid solution
    start(0, "R2 start");
    for (int i = 0; i < N_LEGS * STALL_LIM + N_LEGS; i++)
      iter(8'h11, 8'h22, "R10 fail path");
    cycle_chk("R10 fail held");
    // sweep
    for (int d = 0; d < 40; d++) begin
      start(d[0], "R2 sweep start");
      for (int k = 0; k < N_LEGS * LEG_ITERS && m_busy; k++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        iter((seed[31:29] == 0) ? 8'h00 : seed[7:0] & seed[15:8], seed[23:16],
             "sweep R5 R6 R7 R8 R9 R10");
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule